// File: doc/BRIEF.md
# Dual-Clock Field Memory Buffer

A byte-wide video field store that is read and written strictly in sequence. The writer and the reader run on independent clocks. Each side owns an address pointer that steps forward by one on every enabled cycle, wraps from the last address to zero, and goes back to zero only when that side's own reset input is asserted. There are no full or empty flags. The application keeps the reader a fixed distance behind the writer, or lets it read the previous field at the same address.

New bytes pass through a staging window before they reach the storage array. A byte becomes readable only once the writer has moved `LAG` addresses past it. A read that comes closer than that returns what the array held before, which is the previous field. A write reset drains whatever is still staged into the array. A read reset fetches address 0 into the output register. When both sides share one reset and run with all enables held low, the buffer acts as a one-field delay line. The output comes as a data bus plus a drive flag, which the chip-level pad ring turns into a tri-state driver.

The full-size array is 393,216 words. The default `DEPTH` is smaller so that the array stays small when the block is built with default parameters.

Top module: `field_buffer`

## Requirements
- R1: After `rst_ni` both pointers are 0, `rdrive_o` is 0 and `rdata_o` is 0. A read with no read reset therefore starts at address 0.
- R2: At a `wclk_i` rising edge with `wen_ni` low, `wdata_i` is stored at the write pointer and the pointer advances by one. With `wen_ni` high nothing is stored and the pointer holds.
- R3: At an `rclk_i` rising edge with `ren_ni` low, the byte at the read pointer is loaded into the output register and the pointer advances. With `ren_ni` high both the pointer and the output byte hold.
- R4: If a side's reset (`wrst_ni` or `rrst_ni`, active low) is low at an enabled edge of that side, that edge's access uses address 0 and the pointer becomes 1.
- R5: A reset that is low only during disabled cycles is remembered. It takes effect at the next enabled edge of that side, even if the reset has been released by then.
- R6: `oen_ni` is sampled at every `rclk_i` edge. After an edge that sampled it high, `rdrive_o` is 0 and `rdata_o` is 0. The read pointer still advances on enabled reads while `oen_ni` is high.
- R7: A byte written to address a becomes readable only once the write pointer is at least `LAG` (128) addresses ahead of a. Before that, a read of a returns the array's earlier content.
- R8: A write reset commits every byte still staged. The bytes are drained one per `wclk_i` cycle, whatever `wen_ni` does, within `LAG-1` cycles.
- R9: Both pointers wrap from `DEPTH-1` to 0.
- R10: With a common reset every field on both sides and all enables held low, each byte read equals the byte written at the same address in the previous field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| wdata_i | input | 8 | Write data byte |
| wen_ni | input | 1 | Write enable, active low |
| wrst_ni | input | 1 | Write pointer reset, active low |
| ren_ni | input | 1 | Read enable, active low |
| oen_ni | input | 1 | Output drive enable, active low |
| rrst_ni | input | 1 | Read pointer reset, active low |
| rdata_o | output | 8 | Read data, 0 when not driven |
| rdrive_o | output | 1 | High when the pad should drive rdata_o |

## Verification
The bench reads back a field that was only partly overwritten. Bytes within `LAG` of the write pointer must still show the older field. A design that made them visible too early, or too late, returns the wrong field on either side of that boundary. A short field followed by a long idle period checks that a write reset drains the previous field's staged tail without any enabled write cycles; a design that did not drain would return data two fields old. Resets given only while the side is disabled, read-enable holds, output-disable windows that keep the pointer moving, wrap past the last address and a three-field delay-line run each catch a dropped, lost or double-counted pointer step as a shifted byte sequence.

// File: rtl/ffb_pkg.sv
package ffb_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned FULL_DEPTH = 393216;
  localparam int unsigned DEF_LAG    = 128;
endpackage

// File: rtl/ffb_ram.sv
module ffb_ram #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic                 wclk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  ffb_pkg::byte_t       wdata_i,
  input  logic                 rclk_i,
  input  logic                 re_i,
  input  logic [AW-1:0]        raddr_i,
  output ffb_pkg::byte_t       q_o
);
  ffb_pkg::byte_t mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) q_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ffb_wr_side.sv
module ffb_wr_side #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11,
  parameter int unsigned LAG   = 128
) (
  input  logic           wclk_i,
  input  logic           rst_ni,
  input  ffb_pkg::byte_t wdata_i,
  input  logic           wen_ni,
  input  logic           wrst_ni,
  output logic           ram_we_o,
  output logic [AW-1:0]  ram_addr_o,
  output ffb_pkg::byte_t ram_data_o
);
  localparam int unsigned SLOTS = LAG - 1;
  localparam int unsigned CW    = (LAG > 2) ? $clog2(LAG) : 1;
  localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);

  logic [AW-1:0]  wptr, addr_eff;
  logic           pend, en, rst_req, pop;
  logic [CW-1:0]  head, tail, occ, flush_cnt;
  logic [AW-1:0]  st_addr [SLOTS];
  ffb_pkg::byte_t st_data [SLOTS];

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] slot_nxt(input logic [CW-1:0] s);
    return (s == CW'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  assign en       = !wen_ni;
  assign rst_req  = !wrst_ni || pend;
  assign addr_eff = rst_req ? '0 : wptr;
  // drain while flushing, else retire the oldest when the window is full
  assign pop      = (flush_cnt != '0) || (en && occ == SLOTS_C);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr      <= '0;
      pend      <= 1'b0;
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      flush_cnt <= '0;
    end else begin
      if (en) begin
        wptr <= ptr_nxt(addr_eff);
        tail <= slot_nxt(tail);
      end
      if (pop) head <= slot_nxt(head);
      occ  <= occ + CW'(en) - CW'(pop);
      pend <= en ? 1'b0 : (pend || !wrst_ni);
      if (en && rst_req)         flush_cnt <= occ - CW'(pop);
      else if (flush_cnt != '0)  flush_cnt <= flush_cnt - 1'b1;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (en) begin
      st_addr[tail] <= addr_eff;
      st_data[tail] <= wdata_i;
    end
  end

  assign ram_we_o   = pop;
  assign ram_addr_o = st_addr[head];
  assign ram_data_o = st_data[head];

  // R2
  wptr_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wen_ni |=> $stable(wptr));
  // R4
  wrst_zero_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen_ni && !wrst_ni) |=> (wptr == AW'(1)));
  // R5
  wrst_defer_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen_ni && !wrst_ni) |=> pend);
  // R7
  window_bound_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (occ <= SLOTS_C) && (flush_cnt <= occ));
  // R8
  flush_start_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen_ni && !wrst_ni && occ > CW'(1)) |=> ram_we_o);
endmodule

// File: rtl/ffb_rd_side.sv
module ffb_rd_side #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic           rclk_i,
  input  logic           rst_ni,
  input  logic           ren_ni,
  input  logic           oen_ni,
  input  logic           rrst_ni,
  output logic           ram_re_o,
  output logic [AW-1:0]  ram_addr_o,
  input  ffb_pkg::byte_t ram_q_i,
  output ffb_pkg::byte_t rdata_o,
  output logic           rdrive_o
);
  logic [AW-1:0] rptr;
  logic          pend, en, drive_q;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign en         = !ren_ni;
  assign ram_re_o   = en;
  assign ram_addr_o = (!rrst_ni || pend) ? '0 : rptr;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr    <= '0;
      pend    <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      if (en) rptr <= ptr_nxt(ram_addr_o);
      pend    <= en ? 1'b0 : (pend || !rrst_ni);
      drive_q <= !oen_ni;
    end
  end

  assign rdrive_o = drive_q;
  assign rdata_o  = drive_q ? ram_q_i : '0;

  // R3
  rptr_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_ni |=> ($stable(rptr) && $stable(ram_q_i)));
  // R4
  rrst_zero_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!ren_ni && !rrst_ni) |=> (rptr == AW'(1)));
  // R6
  oe_off_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    oen_ni |=> (!rdrive_o && rdata_o == '0));
  // R6
  oe_ptr_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (oen_ni && !ren_ni && rrst_ni && !pend) |=> (rptr == ptr_nxt($past(rptr))));
endmodule

// File: rtl/field_buffer.sv
module field_buffer #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned LAG   = ffb_pkg::DEF_LAG
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic [7:0] wdata_i,
  input  logic       wen_ni,
  input  logic       wrst_ni,
  input  logic       ren_ni,
  input  logic       oen_ni,
  input  logic       rrst_ni,
  output logic [7:0] rdata_o,
  output logic       rdrive_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic           ram_we, ram_re;
  logic [AW-1:0]  ram_waddr, ram_raddr;
  ffb_pkg::byte_t ram_wdata, ram_q;

  ffb_wr_side #(.DEPTH(DEPTH), .AW(AW), .LAG(LAG)) u_wr (
    .wclk_i, .rst_ni, .wdata_i, .wen_ni, .wrst_ni,
    .ram_we_o(ram_we), .ram_addr_o(ram_waddr), .ram_data_o(ram_wdata)
  );

  ffb_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk_i, .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .rclk_i, .re_i(ram_re), .raddr_i(ram_raddr), .q_o(ram_q)
  );

  ffb_rd_side #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .rclk_i, .rst_ni, .ren_ni, .oen_ni, .rrst_ni,
    .ram_re_o(ram_re), .ram_addr_o(ram_raddr), .ram_q_i(ram_q),
    .rdata_o, .rdrive_o
  );
endmodule

// File: tb/sim_field_buffer.sv
module sim_field_buffer;
  localparam int DEPTH = 512;
  localparam int LAG   = 128;

  logic       wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       wen_ni = 1'b1, wrst_ni = 1'b1;
  logic       ren_ni = 1'b1, oen_ni = 1'b1, rrst_ni = 1'b1;
  logic [7:0] rdata_o;
  logic       rdrive_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_d_q [$];
  logic       exp_v_q [$];
  string      tag_q   [$];

  field_buffer #(.DEPTH(DEPTH), .LAG(LAG)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni, .wdata_i, .wen_ni, .wrst_ni,
    .ren_ni, .oen_ni, .rrst_ni, .rdata_o, .rdrive_o
  );

  always #5 wclk = ~wclk;
  initial begin #2; forever #5 rclk = ~rclk; end

  function automatic logic [7:0] fd(int f, int i);
    return 8'((i * 3 + f * 61 + 5) ^ (i >> 8));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one expected item per read edge that the driver armed
  always @(posedge rclk) begin
    #1;
    if (exp_d_q.size() > 0) begin
      logic [7:0] d;
      logic       v;
      string      t;
      d = exp_d_q.pop_front();
      v = exp_v_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " data"}, 32'(rdata_o), 32'(d));
      chk({t, " drive"}, 32'(rdrive_o), 32'(v));
    end
  end

  task automatic wr(bit en, bit rst, logic [7:0] d);
    @(negedge wclk);
    wen_ni = !en; wrst_ni = !rst; wdata_i = d;
  endtask

  task automatic rd(bit en, bit oe, bit rst, bit armed, logic [7:0] d, string tag);
    @(negedge rclk);
    ren_ni = !en; oen_ni = !oe; rrst_ni = !rst;
    if (armed) begin
      exp_d_q.push_back(oe ? d : 8'h00);
      exp_v_q.push_back(oe);
      tag_q.push_back(tag);
    end
  endtask

  task automatic rd_idle();
    rd(0, 1, 0, 0, 8'h00, "");
  endtask

  task automatic phase_writes_ab();
    // field 1: no write reset, relies on R1; disabled gap must store nothing (R2)
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 100) begin
        wr(0, 0, 8'hEE); wr(0, 0, 8'hEE); wr(0, 0, 8'hEE);
      end
      wr(1, 0, fd(1, i));
    end
    // field 2: reset given only during disabled cycles (R5)
    wr(0, 1, 8'hEE); wr(0, 1, 8'hEE); wr(0, 1, 8'hEE);
    for (int i = 0; i < 200; i++) wr(1, 0, fd(2, i));
    wr(0, 0, 8'h00);
  endtask

  task automatic phase_read_1();
    logic [7:0] last = '0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      automatic int a = k % DEPTH;
      automatic logic [7:0] e = (a <= 72) ? fd(2, a) : fd(1, a);
      automatic bit oe = !(k >= 300 && k < 304);
      automatic string t;
      if (k == 50) begin
        rd(0, 1, 0, 1, last, "R3"); rd(0, 1, 0, 1, last, "R3"); rd(0, 1, 0, 1, last, "R3");
      end
      if (k == 0)            t = "R1";
      else if (k >= DEPTH)   t = "R9";
      else if (!oe)          t = "R6";
      else if (k == 304)     t = "R6";
      else if (a > 72 && a < 200) t = "R7";
      else                   t = "R2";
      rd(1, oe, 0, 1, e, t);
      last = e;
    end
    rd_idle();
  endtask

  task automatic phase_short_field();
    wr(1, 1, fd(3, 0));
    for (int i = 1; i < 10; i++) wr(1, 0, fd(3, i));
    repeat (200) wr(0, 0, 8'h00);
    // deferred read reset (R5)
    rd(0, 1, 1, 0, 8'h00, ""); rd(0, 1, 1, 0, 8'h00, "");
    for (int a = 0; a < DEPTH; a++) begin
      automatic string t = (a == 0) ? "R5" : (a < 10) ? "R7" : (a > 72 && a < 200) ? "R8" : "R3";
      rd(1, 1, 0, 1, (a < 200) ? fd(2, a) : fd(1, a), t);
    end
    rd_idle();
  endtask

  task automatic phase_wrap();
    for (int i = 0; i < DEPTH + 140; i++) wr(1, i == 0, fd(4, i));
    wr(0, 0, 8'h00);
    for (int a = 0; a < 20; a++) begin
      automatic string t = (a == 0) ? "R4" : (a <= 12) ? "R9" : "R7";
      rd(1, 1, a == 0, 1, (a <= 12) ? fd(4, DEPTH + a) : fd(4, a), t);
    end
    rd_idle();
  endtask

  task automatic phase_delay_line();
    fork
      begin
        for (int f = 0; f < 3; f++)
          for (int i = 0; i < DEPTH; i++) wr(1, i == 0, fd(5 + f, i));
        wr(0, 0, 8'h00);
      end
      begin
        for (int f = 0; f < 3; f++)
          for (int i = 0; i < DEPTH; i++) rd(1, 1, i == 0, f > 0, fd(4 + f, i), "R10");
        rd_idle();
      end
    join
  endtask

  initial begin
    repeat (3) @(posedge wclk);
    @(negedge wclk) rst_ni = 1'b1;
    #3;
    // R1
    chk("R1 reset drive", 32'(rdrive_o), 32'd0);
    chk("R1 reset data", 32'(rdata_o), 32'd0);
    phase_writes_ab();
    phase_read_1();
    phase_short_field();
    phase_wrap();
    phase_delay_line();
    repeat (4) @(posedge rclk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule